// File: doc/BRIEF.md
# Atomic Bit-Modify Output Port

This block is the output side of a memory-mapped general-purpose port on an on-chip bus. It holds one output register as wide as the bus word, and this register drives the pins. Software can replace the whole register with one write. It can also change selected bits in a single write, so it never needs a read-modify-write sequence. That keeps updates atomic even when several software contexts share the port, and it lets a full word of pins switch on the same clock edge.

Several write-only alias addresses select the kind of change. The set, clear and toggle aliases act on the whole port. Two more aliases act on only one half of the port, and a one-bit half-select register chooses which half. The first is a combined set/reset word, in which set wins over reset. The second is a mask-and-value word. The bus is a simple single-cycle interface: a write takes effect on the edge at which it is presented, and read data is returned in the same cycle.

Each bus cycle is decoded into one operation. The operations are idle, data write, set, clear, toggle, set/reset, mask/value and half-select write. The block holds no control sequence. Its only state is the output register and the half-select bit.

Top module: `gpio_atom_port`

## Requirements
- R1: After reset, all pins are 0 and the half-select bit is 0.
- R2: A write to word address 0 replaces every output bit with the written word. A read of address 0 returns the current pin state.
- R3: A write to address 1 (set) drives high every pin whose written bit is 1. Pins written as 0 keep their value.
- R4: A write to address 2 (clear) drives low every pin whose written bit is 1. Pins written as 0 keep their value.
- R5: A write to address 3 (toggle) inverts every pin whose written bit is 1. Pins written as 0 keep their value.
- R6: A write to address 4 (set/reset) acts on the selected half of the port. Written bits in the lower half of the word are set requests, and written bits in the upper half are reset requests. The unselected half of the port is unchanged.
- R7: In a set/reset write, a bit that has both a set request and a reset request ends high.
- R8: A write to address 5 (mask/value) acts on the selected half of the port. The upper half of the word is the mask and the lower half is the value. Each pin in the selected half whose mask bit is 1 takes its value bit. All other pins are unchanged.
- R9: Bit 0 of a write to address 6 sets the half-select bit. Its value 0 selects the lower half of the port and 1 selects the upper half. A read of address 6 returns the bit in position 0, with zeros above it.
- R10: Reads of addresses 1 to 5 and 7 return zero. A write to address 7 changes nothing.
- R11: A write changes the pins on the clock edge at which it is presented, with no wait state. Cycles without a write, including read cycles, leave the pins unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle |
| pin_out | output | DATA_W | Output pin levels |

## Verification
On every cycle, the assertions check the following:
- Set, clear and toggle writes leave the unaddressed bits alone and move the addressed bits in the right direction.
- Set wins over reset in each half of the port.
- A mask/value write never disturbs the unselected half.
- Pins stay stable in any cycle without a write.
- Alias reads return zero.

Only the bench's sweeps can show that the exact results are correct:
- Full results of the half-port operations for both half-select values, over every write word and a spread of starting states.
- Read-back of the data register and the half-select bit.
- The same-edge timing of a write.

// File: rtl/gpio_atom_pkg.sv
package gpio_atom_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] ADR_DATA = 3'd0;
    localparam logic [REG_AW-1:0] ADR_SET  = 3'd1;
    localparam logic [REG_AW-1:0] ADR_CLR  = 3'd2;
    localparam logic [REG_AW-1:0] ADR_TGL  = 3'd3;
    localparam logic [REG_AW-1:0] ADR_SRST = 3'd4;
    localparam logic [REG_AW-1:0] ADR_MVAL = 3'd5;
    localparam logic [REG_AW-1:0] ADR_HSEL = 3'd6;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_DATA,
        OP_SET,
        OP_CLR,
        OP_TGL,
        OP_SRST,
        OP_MVAL,
        OP_HSEL
    } op_e;

endpackage

// File: rtl/gpio_atom_decode.sv
module gpio_atom_decode
    import gpio_atom_pkg::*;
(
    input  logic [REG_AW-1:0] addr,
    output op_e               op
);

    always_comb begin
        unique case (addr)
            ADR_DATA: op = OP_DATA;
            ADR_SET:  op = OP_SET;
            ADR_CLR:  op = OP_CLR;
            ADR_TGL:  op = OP_TGL;
            ADR_SRST: op = OP_SRST;
            ADR_MVAL: op = OP_MVAL;
            ADR_HSEL: op = OP_HSEL;
            default:  op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_atom_modify.sv
module gpio_atom_modify
    import gpio_atom_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic              half,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] nxt
);

    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] lo_word;
    logic [HALF_W-1:0] hi_word;
    logic [DATA_W-1:0] half_nxt;

    assign lo_word = wdata[HALF_W-1:0];
    assign hi_word = wdata[DATA_W-1:HALF_W];

    // One merge unit per port half; only the selected half may change.
    for (genvar g = 0; g < 2; g++) begin : g_half
        logic [HALF_W-1:0] cur_h;
        logic [HALF_W-1:0] upd_h;

        assign cur_h = cur[g*HALF_W +: HALF_W];

        always_comb begin
            upd_h = cur_h;
            if (half == 1'(g)) begin
                if (op == OP_SRST) begin
                    // reset first, then set on top: set wins
                    upd_h = (cur_h & ~hi_word) | lo_word;
                end else if (op == OP_MVAL) begin
                    upd_h = (cur_h & ~hi_word) | (lo_word & hi_word);
                end
            end
        end

        assign half_nxt[g*HALF_W +: HALF_W] = upd_h;
    end

    always_comb begin
        unique case (op)
            OP_DATA: nxt = wdata;
            OP_SET:  nxt = cur | wdata;
            OP_CLR:  nxt = cur & ~wdata;
            OP_TGL:  nxt = cur ^ wdata;
            OP_SRST: nxt = half_nxt;
            OP_MVAL: nxt = half_nxt;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/gpio_atom_port.sv
module gpio_atom_port
    import gpio_atom_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [REG_AW-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [DATA_W-1:0]   pin_out
);

    localparam int HALF_W = DATA_W / 2;

    op_e               op_dec;
    op_e               op_wr;
    logic              wr_fire;
    logic              rd_fire;
    logic              half_q;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] out_nxt;

    assign wr_fire = bus_sel & bus_we;
    assign rd_fire = bus_sel & ~bus_we;

    gpio_atom_decode u_decode (
        .addr (bus_addr),
        .op   (op_dec)
    );

    assign op_wr = wr_fire ? op_dec : OP_NONE;

    gpio_atom_modify #(.DATA_W(DATA_W)) u_modify (
        .op    (op_wr),
        .half  (half_q),
        .cur   (out_q),
        .wdata (bus_wdata),
        .nxt   (out_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            half_q <= 1'b0;
        end else begin
            out_q <= out_nxt;
            if (op_wr == OP_HSEL) begin
                half_q <= bus_wdata[0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_fire) begin
            unique case (op_dec)
                OP_DATA: bus_rdata = out_q;
                OP_HSEL: bus_rdata = {{(DATA_W-1){1'b0}}, half_q};
                default: bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = out_q;

    // R3
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && op_dec == OP_SET) |=>
            ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
            ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

    // R4
    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && op_dec == OP_CLR) |=>
            ((pin_out & $past(bus_wdata)) == '0) &&
            ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

    // R5
    p_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && op_dec == OP_TGL) |=>
            ((pin_out ^ $past(pin_out)) == $past(bus_wdata)));

    // R7: set requests end high in the selected half
    p_srst_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && op_dec == OP_SRST && !half_q) |=>
            ((pin_out[HALF_W-1:0] & $past(bus_wdata[HALF_W-1:0])) == $past(bus_wdata[HALF_W-1:0])));

    p_srst_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && op_dec == OP_SRST && half_q) |=>
            ((pin_out[DATA_W-1:HALF_W] & $past(bus_wdata[HALF_W-1:0])) == $past(bus_wdata[HALF_W-1:0])));

    // R8: the unselected half is never disturbed
    p_mval_keep_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && op_dec == OP_MVAL && half_q) |=>
            (pin_out[HALF_W-1:0] == $past(pin_out[HALF_W-1:0])));

    p_mval_keep_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && op_dec == OP_MVAL && !half_q) |=>
            (pin_out[DATA_W-1:HALF_W] == $past(pin_out[DATA_W-1:HALF_W])));

    // R10
    p_alias_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && op_dec != OP_DATA && op_dec != OP_HSEL) |-> (bus_rdata == '0));

    // R11
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_fire) |=> $stable(pin_out));

endmodule

// File: tb/gpio_atom_port_tb.sv
module gpio_atom_port_tb_top;

    localparam int DW = 8;
    localparam int HW = DW / 2;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_SET  = 3'd1;
    localparam logic [2:0] A_CLR  = 3'd2;
    localparam logic [2:0] A_TGL  = 3'd3;
    localparam logic [2:0] A_SRST = 3'd4;
    localparam logic [2:0] A_MVAL = 3'd5;
    localparam logic [2:0] A_HSEL = 3'd6;
    localparam logic [2:0] A_VOID = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] pin_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    gpio_atom_port #(.DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    function automatic logic [DW-1:0] put_half(input logic [DW-1:0] base, input int h,
                                               input logic [HW-1:0] v);
        logic [DW-1:0] r;
        r = base;
        r[h*HW +: HW] = v;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] rv;
        logic [DW-1:0] init;
        logic [DW-1:0] w;
        logic [HW-1:0] cur;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 pins", pin_out, '0);
        rd(A_HSEL, rv);
        chk("R1 halfsel", rv, '0);

        // R2: whole-word write and read-back
        wr(A_DATA, 8'hA5);
        chk("R2 write", pin_out, 8'hA5);
        rd(A_DATA, rv);
        chk("R2 read", rv, 8'hA5);

        // R11: write acts on the edge it is presented at, not earlier
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_DATA; bus_wdata = 8'h3C;
        #1 chk("R11 before edge", pin_out, 8'hA5);
        @(posedge clk); #1;
        chk("R11 after edge", pin_out, 8'h3C);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        // R11: reads do not disturb pins
        rd(A_SET, rv);
        rd(A_DATA, rv);
        chk("R11 read stable", pin_out, 8'h3C);

        // R10: alias reads return zero; unmapped write ignored
        for (int a = 1; a <= 7; a++) begin
            if (a != 6) begin
                rd(3'(a), rv);
                chk("R10 alias read", rv, '0);
            end
        end
        wr(A_VOID, 8'hFF);
        chk("R10 void write", pin_out, 8'h3C);
        rd(A_HSEL, rv);
        chk("R10 void halfsel", rv, '0);

        // R3 R4 R5: full-port sweeps
        for (int i = 0; i < 16; i++) begin
            for (int k = 0; k < 256; k++) begin
                init = 8'(i * 17);
                w = 8'(k);
                wr(A_DATA, init); wr(A_SET, w);
                chk("R3 set", pin_out, init | w);
                wr(A_DATA, init); wr(A_CLR, w);
                chk("R4 clear", pin_out, init & ~w);
                wr(A_DATA, init); wr(A_TGL, w);
                chk("R5 toggle", pin_out, init ^ w);
            end
        end

        // R6 R8 R9: half-port sweeps for each half
        for (int h = 0; h < 2; h++) begin
            wr(A_HSEL, 8'(h) | 8'hF0);
            rd(A_HSEL, rv);
            chk("R9 halfsel readback", rv, 8'(h));
            for (int i = 0; i < 16; i++) begin
                for (int k = 0; k < 256; k++) begin
                    init = 8'(i * 17 + 5);
                    w = 8'(k);
                    cur = init[h*HW +: HW];
                    wr(A_DATA, init); wr(A_SRST, w);
                    chk("R6 set/reset", pin_out,
                        put_half(init, h, (cur & ~w[DW-1:HW]) | w[HW-1:0]));
                    wr(A_DATA, init); wr(A_MVAL, w);
                    chk("R8 mask/value", pin_out,
                        put_half(init, h, (cur & ~w[DW-1:HW]) | (w[HW-1:0] & w[DW-1:HW])));
                end
            end
            // R7: set and reset on every bit of the half -> all high
            wr(A_DATA, 8'h00); wr(A_SRST, 8'hFF);
            chk("R7 set priority", pin_out, put_half(8'h00, h, 4'hF));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule